// File: doc/BRIEF.md
# Instruction Retry Controller

This block steers hardware recovery in an out-of-order core whose architectural registers and memory change only when an instruction commits. When the pipeline reports an error or a hang, the controller first raises a flush request. The request cancels every instruction still in flight and throws away all uncommitted results, so only work that committed cleanly is left in architectural state. Recovery starts on its own, without software. The controller then switches the pipeline into single-step mode, in which one instruction issues and commits at a time. A clean commit in that mode returns the core to normal execution, again without software.

Each fault seen during single-step mode counts as one failed retry. A failed retry causes another flush followed by another single step. When the number of failed retries goes above a programmable limit, the controller stops retrying and raises an interrupt. The interrupt stays raised until software acknowledges it, and the acknowledge returns the controller to normal mode.

Top module: `retry_ctl`

## Requirements
- R1: When `err_det` or `hang_det` is high in normal mode, `flush_o` is high in the next cycle for exactly one cycle.
- R2: A hang report (`hang_det`) follows the same path as an error report in every mode.
- R3: The cycle after a flush cycle, `single_step_o` is high. It stays high until the retry resolves. At most one of `flush_o`, `single_step_o` and `irq_o` is high in any cycle.
- R4: When `commit_ok` is high during single-step mode and no fault is reported, the next cycle is in normal mode: all three control outputs are low and `retry_count` is 0.
- R5: A fault during single-step mode adds one to `retry_count`. If the new count is at most `retry_limit`, the next cycle is a flush, followed by another single step.
- R6: If the new count is above `retry_limit`, the controller enters the report state and `irq_o` goes high. The count saturates at its maximum value of 2^CNT_W-1.
- R7: `irq_o` stays high until `irq_ack` is seen. Faults during the report state have no effect. After the acknowledge, the controller is in normal mode with `retry_count` 0.
- R8: If a fault and `commit_ok` arrive in the same single-step cycle, the cycle counts as a failed retry.
- R9: Faults reported during a flush cycle are ignored. `commit_ok` in normal mode has no effect.
- R10: After reset, the controller is in normal mode with all outputs low and `retry_count` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_det | input | 1 | Error detected in the pipeline |
| hang_det | input | 1 | Hang detected in the pipeline |
| commit_ok | input | 1 | Pulse: an instruction committed without error |
| irq_ack | input | 1 | Software acknowledge of the interrupt |
| retry_limit | input | CNT_W | Failed retries tolerated before reporting |
| flush_o | output | 1 | Cancel all in-flight instructions |
| single_step_o | output | 1 | Pipeline restricted to one instruction at a time |
| irq_o | output | 1 | Interrupt reporting an unrecoverable fault |
| retry_count | output | CNT_W | Failed retries in the current recovery |

## Verification
The assertions assume that `retry_limit` stays constant while a recovery is in progress. They also assume that `irq_ack` matters only in the report state. The stimulus changes the limit only while the controller is in normal mode, and it drives inputs on the falling clock edge, so every pulse lasts exactly one cycle. The bench sweeps several limits, including the saturating maximum. For each limit it tries every count of failed retries from zero to one past the limit, and it alternates between error and hang reports.

// File: rtl/retry_pkg.sv
package retry_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_STEP   = 2'd2,
        ST_REPORT = 2'd3
    } rc_state_e;

    typedef struct packed {
        logic flush;
        logic step;
        logic irq;
    } rc_ctrl_t;

    function automatic rc_ctrl_t decode_ctrl(rc_state_e s);
        rc_ctrl_t c;
        c.flush = (s == ST_FLUSH);
        c.step  = (s == ST_STEP);
        c.irq   = (s == ST_REPORT);
        return c;
    endfunction

endpackage

// File: rtl/retry_counter.sv
module retry_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             next_over
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W:0] cnt_plus;

    always_comb begin
        cnt_plus  = {1'b0, cnt} + 1'b1;
        next_over = cnt_plus > {1'b0, limit};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX) else $error("count wrapped"); // R6

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0) else $error("count not cleared"); // R4
endmodule

// File: rtl/retry_fsm.sv
module retry_fsm
    import retry_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fault,
    input  logic      commit_ok,
    input  logic      irq_ack,
    input  logic      over,
    output rc_state_e state,
    output logic      cnt_inc,
    output logic      cnt_clr
);
    rc_state_e state_nx;

    always_comb begin
        state_nx = state;
        cnt_inc  = 1'b0;
        cnt_clr  = 1'b0;
        unique case (state)
            ST_NORMAL: if (fault) state_nx = ST_FLUSH;
            ST_FLUSH:  state_nx = ST_STEP;
            ST_STEP: begin
                if (fault) begin
                    cnt_inc  = 1'b1;
                    state_nx = over ? ST_REPORT : ST_FLUSH;
                end else if (commit_ok) begin
                    cnt_clr  = 1'b1;
                    state_nx = ST_NORMAL;
                end
            end
            ST_REPORT: begin
                if (irq_ack) begin
                    cnt_clr  = 1'b1;
                    state_nx = ST_NORMAL;
                end
            end
            default: state_nx = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_NORMAL;
        else     state <= state_nx;
    end

    AST_FAULT_STARTS_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && fault) |=> state == ST_FLUSH) else $error("no flush"); // R1

    AST_FLUSH_LEADS_STEP: assert property (@(posedge clk) disable iff (rst)
        state == ST_FLUSH |=> state == ST_STEP) else $error("flush not followed by step"); // R3

    AST_REPORT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REPORT && !irq_ack) |=> state == ST_REPORT) else $error("report dropped"); // R7

    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STEP && fault) |=> state != ST_NORMAL) else $error("fault lost"); // R8
endmodule

// File: rtl/retry_ctl.sv
module retry_ctl
    import retry_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_det,
    input  logic             hang_det,
    input  logic             commit_ok,
    input  logic             irq_ack,
    input  logic [CNT_W-1:0] retry_limit,
    output logic             flush_o,
    output logic             single_step_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] retry_count
);
    rc_state_e state;
    rc_ctrl_t  ctrl;
    logic      fault;
    logic      cnt_inc;
    logic      cnt_clr;
    logic      over;

    assign fault = err_det | hang_det;

    retry_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .fault     (fault),
        .commit_ok (commit_ok),
        .irq_ack   (irq_ack),
        .over      (over),
        .state     (state),
        .cnt_inc   (cnt_inc),
        .cnt_clr   (cnt_clr)
    );

    retry_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .inc       (cnt_inc),
        .clr       (cnt_clr),
        .limit     (retry_limit),
        .cnt       (retry_count),
        .next_over (over)
    );

    always_comb ctrl = decode_ctrl(state);

    assign flush_o       = ctrl.flush;
    assign single_step_o = ctrl.step;
    assign irq_o         = ctrl.irq;

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !flush_o) else $error("flush longer than one cycle"); // R1

    AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flush_o, single_step_o, irq_o})) else $error("outputs overlap"); // R3

    AST_STEP_SUCCESS: assert property (@(posedge clk) disable iff (rst)
        (single_step_o && commit_ok && !fault) |=>
            (!single_step_o && !flush_o && !irq_o && retry_count == '0))
        else $error("clean commit did not resume"); // R4

    AST_HANG_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        (!flush_o && !single_step_o && !irq_o && hang_det) |=> flush_o)
        else $error("hang not flushed"); // R2

    AST_ACK_RESUMES: assert property (@(posedge clk) disable iff (rst)
        (irq_o && irq_ack) |=> (!irq_o && retry_count == '0))
        else $error("ack did not resume"); // R7
endmodule

// File: tb/retry_ctl_bench.sv
module retry_ctl_bench;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             err_det = 1'b0;
    logic             hang_det = 1'b0;
    logic             commit_ok = 1'b0;
    logic             irq_ack = 1'b0;
    logic [CNT_W-1:0] retry_limit = '0;
    logic             flush_o;
    logic             single_step_o;
    logic             irq_o;
    logic [CNT_W-1:0] retry_count;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    retry_ctl #(.CNT_W(CNT_W)) u_retry_ctl (
        .clk           (clk),
        .rst           (rst),
        .err_det       (err_det),
        .hang_det      (hang_det),
        .commit_ok     (commit_ok),
        .irq_ack       (irq_ack),
        .retry_limit   (retry_limit),
        .flush_o       (flush_o),
        .single_step_o (single_step_o),
        .irq_o         (irq_o),
        .retry_count   (retry_count)
    );

    function automatic logic [6:0] pack(logic f, logic s, logic i, int c);
        return {f, s, i, 4'(c)};
    endfunction

    task automatic check(string req, logic [6:0] exp);
        logic [6:0] act;
        act = {flush_o, single_step_o, irq_o, retry_count};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual f/s/i/cnt=%b expected %b", req, act, exp);
        end
    endtask

    // Drive at a falling edge, then return at the next falling edge.
    task automatic cyc(logic e, logic h, logic c, logic a);
        err_det = e; hang_det = h; commit_ok = c; irq_ack = a;
        @(negedge clk);
        err_det = 0; hang_det = 0; commit_ok = 0; irq_ack = 0;
    endtask

    task automatic fault_cyc(logic use_hang, logic with_commit);
        cyc(!use_hang, use_hang, with_commit, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset state", pack(0, 0, 0, 0));

        cyc(0, 0, 1, 0);
        check("R9 commit in normal ignored", pack(0, 0, 0, 0));

        // Limit sweep: idx 4 stands for the saturating maximum.
        for (int li = 0; li < 5; li++) begin
            int thr;
            thr = (li == 4) ? 15 : li;
            retry_limit = 4'(thr);
            for (int f = 0; f <= thr + 1; f++) begin
                logic hg;
                hg = logic'(f[0] ^ li[0]);
                fault_cyc(hg, 1'b0);
                check(hg ? "R2 hang flush" : "R1 error flush", pack(1, 0, 0, 0));
                if (f == 0) begin
                    fault_cyc(!hg, 1'b0);
                    check("R9 fault during flush ignored", pack(0, 1, 0, 0));
                end else begin
                    cyc(0, 0, 0, 0);
                    check("R3 single step after flush", pack(0, 1, 0, 0));
                end
                for (int k = 1; k <= f; k++) begin
                    int ec;
                    ec = (k > 15) ? 15 : k;
                    fault_cyc(logic'(k[0]), logic'(k == 1));
                    if (k > thr) begin
                        check("R6 report on exceed", pack(0, 0, 1, ec));
                    end else begin
                        check(k == 1 ? "R8 fault beats commit" : "R5 reflush", pack(1, 0, 0, ec));
                        cyc(0, 0, 0, 0);
                        check("R5 retry step", pack(0, 1, 0, ec));
                    end
                end
                if (f <= thr) begin
                    cyc(0, 0, 1, 0);
                    check("R4 resume after clean commit", pack(0, 0, 0, 0));
                end else begin
                    cyc(0, 0, 0, 0);
                    check("R7 irq held", pack(0, 0, 1, (thr + 1 > 15) ? 15 : thr + 1));
                    fault_cyc(hg, 1'b0);
                    check("R7 fault in report ignored", pack(0, 0, 1, (thr + 1 > 15) ? 15 : thr + 1));
                    cyc(0, 0, 0, 1);
                    check("R7 ack resumes", pack(0, 0, 0, 0));
                end
                cyc(0, 0, 0, 0);
                check("R1 quiet after recovery", pack(0, 0, 0, 0));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule